// File: doc/BRIEF.md
# System Clock Source Selector and Power-of-Two Divider

This block picks the system clock from five candidates and divides it by a programmable power of two. The five candidates are:

- a fast precision oscillator;
- an external oscillator;
- a low-power oscillator;
- that low-power oscillator slowed down by eight;
- a slow real-time-clock oscillator.

Oscillator inputs are modelled as square-wave levels. All logic runs on one fast reference clock. Each level is brought into that domain by a two-stage synchronizer. The output clock is rebuilt as a registered level.

Software writes a source code and a divide code. A change of source goes through a glitch-free handoff. The old source is gated off while it is low. The new source is connected on its own falling edge.

A change of divide code takes effect only at the end of a divided-clock period. A ready flag drops when the divide code changes. It comes back with the first output rising edge at the new ratio.

The low-power oscillator gets an enable request only while it, or its divided-by-eight form, is selected or is being switched to. When moving to a slower source, software changes the divider first, waits for ready, and then changes the source. When moving to a faster source, it changes the source, then the divider, and then waits for ready.

Top module: `clk_src_sel`

## Requirements
- R1: Source code 0 selects the precision oscillator, 1 the external oscillator, 2 the low-power oscillator, 3 the low-power oscillator divided by 8 (50% duty), and 4 the real-time-clock oscillator. Once settled, the `sys_clk` period equals the selected source period times the divide ratio.
- R2: Divide code k (0 to 7) gives a ratio of 2 to the power k. For every code the settled output has a 50% duty cycle when the source has one.
- R3: After reset the source is code 3, the divide code in effect is 0, `clk_rdy` is high and `lp_osc_en` is high.
- R4: `clk_rdy` is low in the reference cycle after `div_code` moves away from the ratio in effect. It rises in the same cycle as the first `sys_clk` rising edge produced at the new ratio.
- R5: A new ratio is applied only at the end of an output period. No high or low phase of `sys_clk` is shorter than the shorter of the old and new half-periods.
- R6: A source change is glitch-free. The output is held low during the handoff. No phase of `sys_clk` is shorter than the shortest half-period among the configurations passed through.
- R7: `lp_osc_en` is high while source 2 or 3 is in use or is the target of a handoff, and low otherwise.
- R8: Source codes 5, 6 and 7 are ignored. The source in use and `lp_osc_en` are unchanged.
- R9: While `div_code` is steady, `clk_rdy` stays high, including across a source change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_prec | input | 1 | Precision oscillator level |
| osc_ext | input | 1 | External oscillator level |
| osc_lp | input | 1 | Low-power oscillator level |
| osc_rtc | input | 1 | Real-time-clock oscillator level |
| src_sel | input | 3 | Requested source code |
| div_code | input | 3 | Requested divide code (ratio 2^code) |
| sys_clk | output | 1 | Divided system clock level |
| clk_rdy | output | 1 | High when the requested ratio is in effect |
| lp_osc_en | output | 1 | Enable request to the low-power oscillator |

## Verification
The properties take `src_sel` and `div_code` to be register values. They change at most once per reference cycle and are held while a handoff runs. They also take the oscillator levels to have half-periods of several reference cycles, so that every falling edge the handoff waits for does arrive.

The bench drives every oscillator from a fixed-period model clocked on the falling reference edge. The low-power model runs only while its enable is high. Source and divide codes are written one at a time, in the order software must follow. Random draws stay within source codes 0 to 4 and divide codes 0 to 3. The reserved source codes appear only in one directed case.

// File: rtl/clksel_pkg.sv
// Package: shared constants and types of the clock source selector.
// Assumes five candidate sources, coded 0 to 4, and a 3-bit divide code.
package clksel_pkg;
    localparam int N_SRC  = 5;
    localparam int SEL_W  = 3;
    localparam int DIV_W  = 3;
    localparam int LPD_W  = 3;

    localparam logic [SEL_W-1:0] SRC_PREC = 3'd0;
    localparam logic [SEL_W-1:0] SRC_EXT  = 3'd1;
    localparam logic [SEL_W-1:0] SRC_LP   = 3'd2;
    localparam logic [SEL_W-1:0] SRC_LP8  = 3'd3;
    localparam logic [SEL_W-1:0] SRC_RTC  = 3'd4;

    typedef enum logic [1:0] {
        HS_RUN   = 2'd0,
        HS_DRAIN = 2'd1,
        HS_ARM   = 2'd2
    } hand_e;
endpackage

// File: rtl/clksel_sync.sv
// Module: two-stage synchronizer for a bundle of oscillator levels.
// Assumes each input toggles slower than half the reference rate.
module clksel_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            logic s1, s2;
            // Purpose: carry one oscillator level through two flops.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1 <= 1'b0;
                    s2 <= 1'b0;
                end else begin
                    s1 <= raw[g];
                    s2 <= s1;
                end
            end
            assign synced[g] = s2;
        end
    endgenerate
endmodule

// File: rtl/clksel_lpdiv.sv
// Module: derives the divided low-power source from a counter that advances
// on each rising edge of the synchronized low-power level. The top counter bit
// is the output, so it has a 50% duty cycle and a period 2^W input periods long.
// Assumes the input level is already in the reference domain.
module clksel_lpdiv #(
    parameter int W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lp_lvl,
    output logic lp_div
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;
    logic         lp_q;

    // Purpose: count rising edges of the low-power level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            lp_q <= 1'b0;
        end else begin
            lp_q <= lp_lvl;
            if (lp_lvl && !lp_q)
                cnt <= cnt + ONE;
        end
    end

    assign lp_div = cnt[W-1];
endmodule

// File: rtl/clksel_mux.sv
// Module: glitch-free source handoff. In RUN the current candidate is passed
// on. A valid new code starts DRAIN, which waits until the current candidate
// is low and then gates the output off. ARM keeps the output low until the
// target candidate shows a falling edge, and then makes the target current.
// Assumes every candidate keeps toggling (the low-power one gets its enable
// request while it is the target).
module clksel_mux
    import clksel_pkg::*;
#(
    parameter int               NS        = N_SRC,
    parameter logic [SEL_W-1:0] RESET_SRC = SRC_LP8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NS-1:0]    cand,
    input  logic [SEL_W-1:0] sel,
    output logic             mux_lvl,
    output logic [SEL_W-1:0] cur_src,
    output logic             lp_req
);
    localparam logic [SEL_W-1:0] NS_CODE = SEL_W'(NS);

    hand_e            state;
    logic [SEL_W-1:0] tgt;
    logic [NS-1:0]    cand_q;
    logic             sel_ok;

    assign sel_ok = (sel < NS_CODE);

    // Purpose: step the handoff and register the muxed level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= HS_RUN;
            cur_src <= RESET_SRC;
            tgt     <= RESET_SRC;
            mux_lvl <= 1'b0;
            cand_q  <= '0;
        end else begin
            cand_q <= cand;
            case (state)
                HS_RUN: begin
                    mux_lvl <= cand[cur_src];
                    if (sel_ok && (sel != cur_src)) begin
                        tgt   <= sel;
                        state <= HS_DRAIN;
                    end
                end
                HS_DRAIN: begin
                    if (!cand[cur_src]) begin
                        mux_lvl <= 1'b0;
                        state   <= HS_ARM;
                    end else begin
                        mux_lvl <= cand[cur_src];
                    end
                end
                HS_ARM: begin
                    mux_lvl <= 1'b0;
                    if (cand_q[tgt] && !cand[tgt]) begin
                        cur_src <= tgt;
                        state   <= HS_RUN;
                    end
                end
                default: state <= HS_RUN;
            endcase
        end
    end

    // Purpose: request the low-power oscillator while it is used or targeted.
    always_comb begin
        lp_req = (cur_src == SRC_LP) || (cur_src == SRC_LP8);
        if ((state != HS_RUN) && ((tgt == SRC_LP) || (tgt == SRC_LP8)))
            lp_req = 1'b1;
    end
endmodule

// File: rtl/clksel_div.sv
// Module: power-of-two divider with a ready flag. A counter advances on each
// rising edge of the input level, and bit k-1 of the counter is the output for
// code k. Code 0 passes the input level through. A pending code is taken only
// on the input rising edge that closes an output period. At that point the
// counter restarts, and ready waits for the next output rising edge.
// Assumes the input level is in the reference domain.
module clksel_div
    import clksel_pkg::*;
#(
    parameter int KW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_lvl,
    input  logic [KW-1:0] div_code,
    output logic          out_clk,
    output logic          rdy
);
    localparam int             CW    = (1 << KW) - 1;
    localparam logic [CW-1:0]  ONE_C = CW'(1);
    localparam logic [KW-1:0]  ONE_K = KW'(1);

    logic [KW-1:0] act_k, k_nxt, idx;
    logic [CW-1:0] cnt, cnt_nxt, sh, msk;
    logic          in_q, rise, wait_q, wait_nxt, out_nxt;

    // Purpose: low-bit mask that marks the last input period of an output period.
    function automatic logic [CW-1:0] low_mask(input logic [KW-1:0] k);
        logic [CW-1:0] m;
        for (int i = 0; i < CW; i++)
            m[i] = (i < int'(k));
        return m;
    endfunction

    assign rise = in_lvl && !in_q;
    assign msk  = low_mask(act_k);

    // Purpose: next counter, ratio, output level and wait flag.
    always_comb begin
        cnt_nxt  = cnt;
        k_nxt    = act_k;
        wait_nxt = wait_q;
        if (rise) begin
            if (((cnt & msk) == msk) && (div_code != act_k)) begin
                cnt_nxt  = '0;
                k_nxt    = div_code;
                wait_nxt = 1'b1;
            end else begin
                cnt_nxt = cnt + ONE_C;
            end
        end
        idx = k_nxt - ONE_K;
        sh  = cnt_nxt >> idx;
        out_nxt = (k_nxt == '0) ? in_lvl : sh[0];
        if (wait_nxt && out_nxt && !out_clk)
            wait_nxt = 1'b0;
    end

    // Purpose: register divider state, output level and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q    <= 1'b0;
            cnt     <= '0;
            act_k   <= '0;
            wait_q  <= 1'b0;
            out_clk <= 1'b0;
            rdy     <= 1'b1;
        end else begin
            in_q    <= in_lvl;
            cnt     <= cnt_nxt;
            act_k   <= k_nxt;
            wait_q  <= wait_nxt;
            out_clk <= out_nxt;
            rdy     <= (div_code == k_nxt) && !wait_nxt;
        end
    end
endmodule

// File: rtl/clk_src_sel.sv
// Module: top of the clock source selector. It synchronizes the raw
// oscillator levels, derives the divided low-power source, hands off between
// sources without glitches, and divides the result by a power of two.
// Assumes src_sel and div_code are software register values.
module clk_src_sel
    import clksel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_prec,
    input  logic             osc_ext,
    input  logic             osc_lp,
    input  logic             osc_rtc,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [DIV_W-1:0] div_code,
    output logic             sys_clk,
    output logic             clk_rdy,
    output logic             lp_osc_en
);
    logic [3:0]       raw_s;
    logic             lp_div;
    logic [N_SRC-1:0] cand;
    logic             mux_lvl;
    logic [SEL_W-1:0] cur_src;

    clksel_sync #(.W(4)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    ({osc_rtc, osc_lp, osc_ext, osc_prec}),
        .synced (raw_s)
    );

    clksel_lpdiv #(.W(LPD_W)) u_lpdiv (
        .clk    (clk),
        .rst_n  (rst_n),
        .lp_lvl (raw_s[2]),
        .lp_div (lp_div)
    );

    assign cand = {raw_s[3], lp_div, raw_s[2], raw_s[1], raw_s[0]};

    clksel_mux #(.NS(N_SRC), .RESET_SRC(SRC_LP8)) u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .cand    (cand),
        .sel     (src_sel),
        .mux_lvl (mux_lvl),
        .cur_src (cur_src),
        .lp_req  (lp_osc_en)
    );

    clksel_div #(.KW(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_lvl   (mux_lvl),
        .div_code (div_code),
        .out_clk  (sys_clk),
        .rdy      (clk_rdy)
    );
endmodule

// File: rtl/clksel_checker.sv
// Module: properties of the clock source selector, bound to its top.
// Assumes the register inputs change at most once per reference cycle.
module clksel_checker
    import clksel_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] div_code,
    input logic             clk_rdy,
    input logic             sys_clk,
    input logic [SEL_W-1:0] cur_src,
    input logic             mux_lvl
);
    logic live;

    // Purpose: mark cycles whose sampled history lies entirely after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    a_r4_rdy_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (live && clk_rdy && !$stable(div_code)) |=> !clk_rdy);

    a_r9_rdy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (live && clk_rdy && $stable(div_code)) |=> clk_rdy);

    a_r4_rdy_with_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $rose(clk_rdy)) |-> $rose(sys_clk));

    a_r6_handoff_low: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !$stable(cur_src)) |-> !mux_lvl);

    a_r8_src_range: assert property (@(posedge clk) disable iff (!rst_n)
        cur_src < SEL_W'(N_SRC));
endmodule

bind clk_src_sel clksel_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_code (div_code),
    .clk_rdy  (clk_rdy),
    .sys_clk  (sys_clk),
    .cur_src  (cur_src),
    .mux_lvl  (mux_lvl)
);

// File: tb/clk_src_sel_test.sv
// Bench: fixed-period oscillator models, directed and seeded random switches,
// and checks of period, duty, phase width and ready timing.
module clk_src_sel_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic osc_prec = 1'b0, osc_ext = 1'b0, osc_lp = 1'b0, osc_rtc = 1'b0;
    logic [2:0] src_sel = 3'd3, div_code = 3'd0;
    logic sys_clk, clk_rdy, lp_osc_en;

    int n_chk = 0, n_err = 0;
    int cyc = 0, rises = 0, rise_t = 0, fall_t = 0, per_last = 0, hi_last = 0;
    bit have_rise = 0, have_fall = 0, prev_s = 0, rdy_low_seen = 0, done = 0;
    int min_ok = 40;
    int cur_s = 3, cur_k = 0;
    int c_prec = 0, c_ext = 0, c_lp = 0, c_rtc = 0;

    clk_src_sel uut (
        .clk(clk), .rst_n(rst_n), .osc_prec(osc_prec), .osc_ext(osc_ext),
        .osc_lp(osc_lp), .osc_rtc(osc_rtc), .src_sel(src_sel),
        .div_code(div_code), .sys_clk(sys_clk), .clk_rdy(clk_rdy),
        .lp_osc_en(lp_osc_en)
    );

    always #5 clk = ~clk;

    function automatic int src_per(input int s);
        case (s)
            0: return 4;
            1: return 6;
            2: return 10;
            3: return 80;
            default: return 32;
        endcase
    endfunction

    function automatic int half_of(input int s, input int k);
        return (src_per(s) << k) / 2;
    endfunction

    function automatic int min3(input int a, input int b, input int c);
        int m = a;
        if (b < m) m = b;
        if (c < m) m = c;
        return m;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Oscillator models, stepped on the falling reference edge.
    always @(negedge clk) begin
        c_prec <= (c_prec == 1) ? 0 : c_prec + 1;
        if (c_prec == 1) osc_prec <= ~osc_prec;
        c_ext <= (c_ext == 2) ? 0 : c_ext + 1;
        if (c_ext == 2) osc_ext <= ~osc_ext;
        c_rtc <= (c_rtc == 15) ? 0 : c_rtc + 1;
        if (c_rtc == 15) osc_rtc <= ~osc_rtc;
        if (!lp_osc_en) begin
            c_lp <= 0;
            osc_lp <= 1'b0;
        end else begin
            c_lp <= (c_lp == 4) ? 0 : c_lp + 1;
            if (c_lp == 4) osc_lp <= ~osc_lp;
        end
    end

    // Output monitor: periods, high phases and minimum phase width (R5, R6).
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!clk_rdy) rdy_low_seen = 1;
            if (sys_clk && !prev_s) begin
                if (have_rise) per_last = cyc - rise_t;
                if (have_fall)
                    check((cyc - fall_t) >= min_ok, "R5/R6 low phase", cyc - fall_t, min_ok);
                rise_t = cyc;
                have_rise = 1;
                rises++;
            end
            if (!sys_clk && prev_s) begin
                if (have_rise) begin
                    hi_last = cyc - rise_t;
                    check(hi_last >= min_ok, "R5/R6 high phase", hi_last, min_ok);
                end
                fall_t = cyc;
                have_fall = 1;
            end
            prev_s = sys_clk;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 190000 && !done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic wait_rises(input int n);
        int r0 = rises;
        while (rises < r0 + n) @(negedge clk);
        #1;
    endtask

    task automatic measure(input string tag, input int s, input int k);
        wait_rises(3);
        check(per_last == (src_per(s) << k), {tag, " period"}, per_last, src_per(s) << k);
        check(hi_last == half_of(s, k), {"R2 duty ", tag}, hi_last, half_of(s, k));
    endtask

    task automatic set_div(input int k);
        @(negedge clk);
        div_code = 3'(k);
        @(negedge clk);
        check(clk_rdy == 1'b0, "R4 ready low after divide change", clk_rdy, 0);
    endtask

    task automatic wait_rdy();
        bit p;
        int t = 0;
        p = sys_clk;
        while (!clk_rdy && t < 30000) begin
            @(negedge clk);
            #1;
            if (clk_rdy)
                check(sys_clk && !p, "R4 ready rises with output edge", {p, sys_clk}, 1);
            p = sys_clk;
            t++;
        end
        check(clk_rdy == 1'b1, "R4 ready returns", clk_rdy, 1);
    endtask

    task automatic set_src(input int s);
        @(negedge clk);
        src_sel = 3'(s);
    endtask

    // Full switch in the order software follows for the speed relation.
    task automatic do_switch(input int s, input int k);
        min_ok = min3(half_of(cur_s, cur_k), half_of(cur_s, k), half_of(s, cur_k));
        if (half_of(s, k) < min_ok) min_ok = half_of(s, k);
        rdy_low_seen = 0;
        if (src_per(s) > src_per(cur_s)) begin
            if (k != cur_k) begin set_div(k); wait_rdy(); end
            set_src(s);
        end else begin
            set_src(s);
            if (k != cur_k) begin set_div(k); wait_rdy(); end
        end
        measure("R1 source", s, k);
        if (k == cur_k)
            check(!rdy_low_seen, "R9 ready steady across source change", rdy_low_seen, 0);
        check(lp_osc_en == (s == 2 || s == 3), "R7 low-power enable", lp_osc_en, s == 2 || s == 3);
        cur_s = s;
        cur_k = k;
        min_ok = half_of(s, k);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(clk_rdy == 1'b1, "R3 ready after reset", clk_rdy, 1);
        check(lp_osc_en == 1'b1, "R3 low-power enable after reset", lp_osc_en, 1);
        measure("R3 reset source", 3, 0);

        do_switch(0, 0);
        for (int k = 1; k < 8; k++) begin
            min_ok = half_of(0, k - 1);
            set_div(k);
            wait_rdy();
            measure("R2 divide", 0, k);
            cur_k = k;
        end
        min_ok = half_of(0, 0);
        set_div(0);
        wait_rdy();
        measure("R5 ratio back to one", 0, 0);
        cur_k = 0;

        set_src(5);
        repeat (40) @(negedge clk);
        set_src(7);
        repeat (40) @(negedge clk);
        #1;
        measure("R8 reserved code ignored", 0, 0);
        check(lp_osc_en == 1'b0, "R8 enable unchanged by reserved code", lp_osc_en, 0);
        set_src(0);

        do_switch(1, 1);
        do_switch(2, 1);
        do_switch(3, 1);
        do_switch(4, 1);
        do_switch(0, 2);
        do_switch(3, 0);

        for (int i = 0; i < 12; i++)
            do_switch(int'($urandom % 5), int'($urandom % 4));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule